// File: doc/BRIEF.md
# L1 Miss Completion Controller

This block finishes the outstanding misses of a private L1 cache in a directory-based MESI protocol. A table of in-flight transactions holds one entry per missing line, with the line address and a transient state. The transient state is one of: load miss pending, load miss pending but invalidated meanwhile, store miss without a copy, or store upgrade from shared. Core requests come in on a valid/ready stream. The stable state of the addressed line is supplied with each request by the tag lookup. Requests that hit complete on the next cycle. Requests that miss are parked in the table.

Responses from the interconnect arrive on a second valid/ready stream. For each response the block looks up the table entry, applies the transition, and emits the results as one-cycle registered pulses one cycle later. The results are a fill of the line into the data array, a stable-state update, an unblock or exclusive unblock to the directory, a completion to the core, and a wakeup for requests waiting on that address. Every completion carries a miss tag, so hit and miss latencies can be accumulated separately. Two pairs of counters do this. A load miss whose line was invalidated while pending still returns its data once.

Back-pressure: `rsp_ready` is always high; every response is consumed in the cycle it is valid. `cr_ready` depends on `rsp_valid` and on the request's own address and state, never on `cr_valid`. It is low in three cases: while a response is valid, while the request's address has a live entry, or when a miss finds the table full. A request is taken on a cycle where both `cr_valid` and `cr_ready` are high. Requests held back this way go through once the matching wakeup has freed the entry.

Top module: `l1_miss_finisher`

## Requirements
- R1: After reset all output pulses and all four counters are zero, and `cr_ready` is 1 while `rsp_valid` is 0 and the table is empty. Stable-state encoding on `cr_state` and `st_upd_state`: 0=I, 1=S, 2=E, 3=M.
- R2: A load with state S, E or M and a store with state E or M complete one cycle after acceptance with `cmpl_miss`=0. A store hit also updates the line to M (3) with `st_upd_dirty`=1, and a load hit issues no state update. Other requests allocate an entry instead: a load in I becomes a pending load, a store in I a store miss, a store in S an upgrade.
- R3: Response kind encoding on `rsp_kind`: 0=data with all acks, 1=data from a peer L1, 2=exclusive data, 3=all acks. For a pending load, kind 0 fills the line, sends no unblock, completes the load with `cmpl_miss`=1 and sets S.
- R4: `inv_valid` on the address of a pending load (also in the same cycle as its response) marks it invalidated. Kinds 0 and 1 then leave the line in I while still completing the load once. An invalidate on any other entry kind has no effect.
- R5: Kind 1 on a pending load fills, sends a non-exclusive unblock (`unblk_excl`=0), completes the load as a miss, and sets S, or I if invalidated.
- R6: Kind 2 on a pending load, invalidated or not, fills, sends an exclusive unblock, completes the load as a miss, and sets E.
- R7: Kind 0 on a store miss fills, sends an exclusive unblock, completes the store as a miss, and sets M with dirty=1.
- R8: Kind 3 on an upgrade sends an exclusive unblock, completes the store as a miss, and sets M with dirty=1, without a fill.
- R9: Every accepted legal response frees its entry and pulses `wake_valid` with its address together with the miss completion; `rsp_ready` is always 1.
- R10: A response with no live entry for its address, or of a kind not listed for the entry's state, pulses `proto_err` one cycle later. It produces no other output and leaves the entry in place.
- R11: `cr_ready` is 0 while `rsp_valid` is 1, for any request whose address has a live entry, and for misses when all ENTRIES (4) entries are live. Hits to other addresses still pass while the table is full.
- R12: `hit_events`/`miss_events` count hit and miss completions. Each hit adds 1 to `hit_cycles`. Each miss adds to `miss_cycles` the number of clock edges from the edge that accepted the request to the edge that accepted the response, plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cr_valid | input | 1 | Core request valid |
| cr_ready | output | 1 | Core request accepted when high with valid |
| cr_store | input | 1 | 1 = store, 0 = load |
| cr_addr | input | ADDR_W | Line address of the request |
| cr_state | input | 2 | Stable state of the line from tag lookup |
| rsp_valid | input | 1 | Interconnect response valid |
| rsp_ready | output | 1 | Always 1 |
| rsp_kind | input | 2 | Response kind |
| rsp_addr | input | ADDR_W | Line address of the response |
| inv_valid | input | 1 | Invalidate for a line |
| inv_addr | input | ADDR_W | Address of the invalidate |
| fill_valid | output | 1 | Write response data into the array |
| fill_addr | output | ADDR_W | Line to fill |
| st_upd_valid | output | 1 | Stable-state update |
| st_upd_addr | output | ADDR_W | Line of the update |
| st_upd_state | output | 2 | New stable state |
| st_upd_dirty | output | 1 | New dirty bit |
| unblk_valid | output | 1 | Unblock message to the directory |
| unblk_excl | output | 1 | 1 = exclusive unblock |
| unblk_addr | output | ADDR_W | Line of the unblock |
| cmpl_valid | output | 1 | Completion to the core |
| cmpl_store | output | 1 | Completion is for a store |
| cmpl_miss | output | 1 | Completion came from a miss |
| cmpl_addr | output | ADDR_W | Line of the completion |
| wake_valid | output | 1 | Wake requests parked on this address |
| wake_addr | output | ADDR_W | Address to wake |
| proto_err | output | 1 | Response dropped as a protocol error |
| hit_events | output | CNT_W | Number of hit completions |
| hit_cycles | output | CNT_W | Accumulated hit latency |
| miss_events | output | CNT_W | Number of miss completions |
| miss_cycles | output | CNT_W | Accumulated miss latency |

## Verification
The bench sweeps every transient state against every response kind. A transition table with a wrong cell would show up as a bad state, a missing or non-exclusive unblock, a fill on an acks-only message, or a completion for an illegal kind instead of a protocol error. It also checks that an illegal kind leaves the entry in place by probing the held request and completing the entry afterwards. Further directed cases cover:
- an invalidate arriving in the same cycle as the data, which a design that samples the old state would leave in S;
- an invalidate on a store miss, which must not disturb it;
- a full table, which must still admit hits;
- a response blocking a core request.

The latency sums are compared with edge counts taken in the bench, which exposes an off-by-one in the entry age.

// File: rtl/l1mf_pkg.sv
package l1mf_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } stable_e;

  typedef enum logic [1:0] {
    TS_LD      = 2'd0,  // load miss pending
    TS_LD_INV  = 2'd1,  // load miss pending, line invalidated meanwhile
    TS_ST      = 2'd2,  // store miss, no copy held
    TS_UPG     = 2'd3   // store upgrade from shared
  } pend_e;

  typedef enum logic [1:0] {
    RK_DATA_ACKS = 2'd0,
    RK_DATA_PEER = 2'd1,
    RK_DATA_EXCL = 2'd2,
    RK_ACKS_ONLY = 2'd3
  } rkind_e;

  typedef struct packed {
    logic    legal;
    logic    fill;
    logic    unblk;
    logic    unblk_excl;
    logic    store;
    logic    dirty;
    stable_e next;
  } act_t;

endpackage

// File: rtl/l1mf_resp_decode.sv
module l1mf_resp_decode
  import l1mf_pkg::*;
(
  input  pend_e  st,
  input  rkind_e kind,
  output act_t   act
);

  logic invalidated;
  assign invalidated = (st == TS_LD_INV);

  always_comb begin
    act = '{legal: 1'b0, fill: 1'b0, unblk: 1'b0, unblk_excl: 1'b0,
            store: 1'b0, dirty: 1'b0, next: ST_I};
    unique case (st)
      TS_LD, TS_LD_INV: begin
        unique case (kind)
          RK_DATA_ACKS: begin
            act.legal = 1'b1;
            act.fill  = 1'b1;
            act.next  = invalidated ? ST_I : ST_S;
          end
          RK_DATA_PEER: begin
            act.legal = 1'b1;
            act.fill  = 1'b1;
            act.unblk = 1'b1;
            act.next  = invalidated ? ST_I : ST_S;
          end
          RK_DATA_EXCL: begin
            act.legal      = 1'b1;
            act.fill       = 1'b1;
            act.unblk      = 1'b1;
            act.unblk_excl = 1'b1;
            act.next       = ST_E;
          end
          default: act.legal = 1'b0;
        endcase
      end
      TS_ST: begin
        if (kind == RK_DATA_ACKS) begin
          act.legal      = 1'b1;
          act.fill       = 1'b1;
          act.unblk      = 1'b1;
          act.unblk_excl = 1'b1;
          act.store      = 1'b1;
          act.dirty      = 1'b1;
          act.next       = ST_M;
        end
      end
      TS_UPG: begin
        if (kind == RK_ACKS_ONLY) begin
          act.legal      = 1'b1;
          act.unblk      = 1'b1;
          act.unblk_excl = 1'b1;
          act.store      = 1'b1;
          act.dirty      = 1'b1;
          act.next       = ST_M;
        end
      end
      default: act.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/l1mf_txn_table.sv
module l1mf_txn_table
  import l1mf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int CYC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              full,
  input  logic              alloc_en,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  pend_e             alloc_state,
  input  logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_hit,
  output pend_e             rsp_state,
  output logic [CYC_W-1:0]  rsp_age,
  input  logic              free_en,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr
);

  localparam logic [CYC_W-1:0] AGE_MAX = {CYC_W{1'b1}};

  logic [ENTRIES-1:0] e_vld;
  logic [ENTRIES-1:0] lk_m;
  logic [ENTRIES-1:0] rsp_m;
  logic [ENTRIES-1:0] inv_m;
  logic [ENTRIES-1:0] slot_oh;
  logic [ADDR_W-1:0]  e_addr [ENTRIES];
  pend_e              e_st   [ENTRIES];
  logic [CYC_W-1:0]   e_age  [ENTRIES];

  // lowest free slot
  always_comb begin
    logic found;
    found   = 1'b0;
    slot_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!e_vld[i] && !found) begin
        slot_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign lk_m[g]  = e_vld[g] && (e_addr[g] == lk_addr);
    assign rsp_m[g] = e_vld[g] && (e_addr[g] == rsp_addr);
    assign inv_m[g] = e_vld[g] && inv_valid && (e_addr[g] == inv_addr);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_vld[g]  <= 1'b0;
        e_addr[g] <= '0;
        e_st[g]   <= TS_LD;
        e_age[g]  <= '0;
      end else if (free_en && rsp_m[g]) begin
        e_vld[g] <= 1'b0;
      end else if (alloc_en && slot_oh[g]) begin
        e_vld[g]  <= 1'b1;
        e_addr[g] <= alloc_addr;
        e_st[g]   <= alloc_state;
        e_age[g]  <= {{(CYC_W-1){1'b0}}, 1'b1};
      end else if (e_vld[g]) begin
        if (e_age[g] != AGE_MAX) e_age[g] <= e_age[g] + 1'b1;
        if (inv_m[g] && e_st[g] == TS_LD) e_st[g] <= TS_LD_INV;
      end
    end
  end

  assign lk_hit  = |lk_m;
  assign rsp_hit = |rsp_m;
  assign full    = &e_vld;

  // state seen by the response, with a same-cycle invalidate folded in
  always_comb begin
    rsp_state = TS_LD;
    rsp_age   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rsp_m[i]) begin
        rsp_state = e_st[i];
        rsp_age   = e_age[i];
      end
    end
    if (inv_valid && inv_addr == rsp_addr && rsp_state == TS_LD)
      rsp_state = TS_LD_INV;
  end

endmodule

// File: rtl/l1mf_lat_stats.sv
module l1mf_lat_stats #(
  parameter int CYC_W = 16,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_evt,
  input  logic             miss_evt,
  input  logic [CYC_W:0]   miss_lat,
  output logic [CNT_W-1:0] hit_events,
  output logic [CNT_W-1:0] hit_cycles,
  output logic [CNT_W-1:0] miss_events,
  output logic [CNT_W-1:0] miss_cycles
);

  localparam int PAD_W = CNT_W - CYC_W - 1;

  logic [CNT_W-1:0] lat_ext;
  assign lat_ext = {{PAD_W{1'b0}}, miss_lat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_events  <= '0;
      hit_cycles  <= '0;
      miss_events <= '0;
      miss_cycles <= '0;
    end else begin
      if (hit_evt) begin
        hit_events <= hit_events + 1'b1;
        hit_cycles <= hit_cycles + 1'b1;
      end
      if (miss_evt) begin
        miss_events <= miss_events + 1'b1;
        miss_cycles <= miss_cycles + lat_ext;
      end
    end
  end

endmodule

// File: rtl/l1_miss_finisher.sv
module l1_miss_finisher
  import l1mf_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 16,
  parameter int CYC_W   = 16,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_valid,
  output logic              cr_ready,
  input  logic              cr_store,
  input  logic [ADDR_W-1:0] cr_addr,
  input  logic [1:0]        cr_state,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [1:0]        rsp_kind,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              inv_valid,
  input  logic [ADDR_W-1:0] inv_addr,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              st_upd_valid,
  output logic [ADDR_W-1:0] st_upd_addr,
  output logic [1:0]        st_upd_state,
  output logic              st_upd_dirty,
  output logic              unblk_valid,
  output logic              unblk_excl,
  output logic [ADDR_W-1:0] unblk_addr,
  output logic              cmpl_valid,
  output logic              cmpl_store,
  output logic              cmpl_miss,
  output logic [ADDR_W-1:0] cmpl_addr,
  output logic              wake_valid,
  output logic [ADDR_W-1:0] wake_addr,
  output logic              proto_err,
  output logic [CNT_W-1:0]  hit_events,
  output logic [CNT_W-1:0]  hit_cycles,
  output logic [CNT_W-1:0]  miss_events,
  output logic [CNT_W-1:0]  miss_cycles
);

  stable_e          cr_st;
  logic             cr_hit;
  logic             cr_fire;
  logic             hit_fire;
  logic             lk_hit;
  logic             tbl_full;
  logic             alloc_en;
  pend_e            alloc_state;
  logic             rsp_hit;
  pend_e            rsp_state;
  logic [CYC_W-1:0] rsp_age;
  act_t             act;
  logic             rsp_ok;
  logic             rsp_bad;
  logic [CYC_W:0]   miss_lat;

  assign cr_st  = stable_e'(cr_state);
  assign cr_hit = cr_store ? (cr_st == ST_E || cr_st == ST_M) : (cr_st != ST_I);

  // responses own the completion port; a live address or a full table holds misses
  assign cr_ready = !rsp_valid && !lk_hit && (cr_hit || !tbl_full);
  assign cr_fire  = cr_valid && cr_ready;
  assign hit_fire = cr_fire && cr_hit;
  assign alloc_en = cr_fire && !cr_hit;

  always_comb begin
    if (!cr_store)          alloc_state = TS_LD;
    else if (cr_st == ST_S) alloc_state = TS_UPG;
    else                    alloc_state = TS_ST;
  end

  assign rsp_ready = 1'b1;

  l1mf_txn_table #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .CYC_W   (CYC_W)
  ) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_addr     (cr_addr),
    .lk_hit      (lk_hit),
    .full        (tbl_full),
    .alloc_en    (alloc_en),
    .alloc_addr  (cr_addr),
    .alloc_state (alloc_state),
    .rsp_addr    (rsp_addr),
    .rsp_hit     (rsp_hit),
    .rsp_state   (rsp_state),
    .rsp_age     (rsp_age),
    .free_en     (rsp_ok),
    .inv_valid   (inv_valid),
    .inv_addr    (inv_addr)
  );

  l1mf_resp_decode u_dec (
    .st   (rsp_state),
    .kind (rkind_e'(rsp_kind)),
    .act  (act)
  );

  assign rsp_ok   = rsp_valid && rsp_hit && act.legal;
  assign rsp_bad  = rsp_valid && !rsp_ok;
  assign miss_lat = {1'b0, rsp_age} + 1'b1;

  l1mf_lat_stats #(
    .CYC_W (CYC_W),
    .CNT_W (CNT_W)
  ) u_stats (
    .clk         (clk),
    .rst_n       (rst_n),
    .hit_evt     (hit_fire),
    .miss_evt    (rsp_ok),
    .miss_lat    (miss_lat),
    .hit_events  (hit_events),
    .hit_cycles  (hit_cycles),
    .miss_events (miss_events),
    .miss_cycles (miss_cycles)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_valid   <= 1'b0;
      fill_addr    <= '0;
      st_upd_valid <= 1'b0;
      st_upd_addr  <= '0;
      st_upd_state <= 2'd0;
      st_upd_dirty <= 1'b0;
      unblk_valid  <= 1'b0;
      unblk_excl   <= 1'b0;
      unblk_addr   <= '0;
      cmpl_valid   <= 1'b0;
      cmpl_store   <= 1'b0;
      cmpl_miss    <= 1'b0;
      cmpl_addr    <= '0;
      wake_valid   <= 1'b0;
      wake_addr    <= '0;
      proto_err    <= 1'b0;
    end else begin
      proto_err   <= rsp_bad;
      fill_valid  <= rsp_ok && act.fill;
      fill_addr   <= rsp_addr;
      unblk_valid <= rsp_ok && act.unblk;
      unblk_excl  <= rsp_ok && act.unblk_excl;
      unblk_addr  <= rsp_addr;
      wake_valid  <= rsp_ok;
      wake_addr   <= rsp_addr;
      if (rsp_ok) begin
        cmpl_valid   <= 1'b1;
        cmpl_miss    <= 1'b1;
        cmpl_store   <= act.store;
        cmpl_addr    <= rsp_addr;
        st_upd_valid <= 1'b1;
        st_upd_addr  <= rsp_addr;
        st_upd_state <= act.next;
        st_upd_dirty <= act.dirty;
      end else begin
        cmpl_valid   <= hit_fire;
        cmpl_miss    <= 1'b0;
        cmpl_store   <= cr_store;
        cmpl_addr    <= cr_addr;
        st_upd_valid <= hit_fire && cr_store;
        st_upd_addr  <= cr_addr;
        st_upd_state <= ST_M;
        st_upd_dirty <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/l1mf_chk.sv
module l1mf_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cr_ready,
  input logic             rsp_valid,
  input logic             fill_valid,
  input logic             st_upd_valid,
  input logic [1:0]       st_upd_state,
  input logic             st_upd_dirty,
  input logic             unblk_valid,
  input logic             unblk_excl,
  input logic             cmpl_valid,
  input logic             cmpl_store,
  input logic             cmpl_miss,
  input logic             wake_valid,
  input logic             proto_err,
  input logic [CNT_W-1:0] miss_events
);

  // R2
  store_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid && cmpl_store |-> st_upd_valid && st_upd_dirty && st_upd_state == 2'd3);

  // R6
  excl_unblk_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unblk_valid && unblk_excl |-> st_upd_valid && st_upd_state[1]);

  // R9
  miss_cmpl_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid && cmpl_miss |-> $past(rsp_valid));

  // R9
  wake_with_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> cmpl_valid && cmpl_miss);

  // R10
  err_is_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !cmpl_valid && !fill_valid && !unblk_valid && !wake_valid && !st_upd_valid);

  // R11
  rsp_blocks_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cr_ready);

  // R12
  miss_count_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid && cmpl_miss |-> miss_events != $past(miss_events));

  // R12
  miss_count_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmpl_valid && cmpl_miss) |-> $stable(miss_events));

endmodule

bind l1_miss_finisher l1mf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cr_ready     (cr_ready),
  .rsp_valid    (rsp_valid),
  .fill_valid   (fill_valid),
  .st_upd_valid (st_upd_valid),
  .st_upd_state (st_upd_state),
  .st_upd_dirty (st_upd_dirty),
  .unblk_valid  (unblk_valid),
  .unblk_excl   (unblk_excl),
  .cmpl_valid   (cmpl_valid),
  .cmpl_store   (cmpl_store),
  .cmpl_miss    (cmpl_miss),
  .wake_valid   (wake_valid),
  .proto_err    (proto_err),
  .miss_events  (miss_events)
);

// File: tb/l1_miss_finisher_tb.sv
`timescale 1ns/1ps
module l1_miss_finisher_tb;

  localparam int AW = 16;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cr_valid = 1'b0, cr_store = 1'b0;
  logic [AW-1:0] cr_addr = '0;
  logic [1:0]    cr_state = 2'd0;
  logic          rsp_valid = 1'b0;
  logic [1:0]    rsp_kind = 2'd0;
  logic [AW-1:0] rsp_addr = '0;
  logic          inv_valid = 1'b0;
  logic [AW-1:0] inv_addr = '0;
  logic          cr_ready, rsp_ready;
  logic          fill_valid, st_upd_valid, st_upd_dirty, unblk_valid, unblk_excl;
  logic          cmpl_valid, cmpl_store, cmpl_miss, wake_valid, proto_err;
  logic [AW-1:0] fill_addr, st_upd_addr, unblk_addr, cmpl_addr, wake_addr;
  logic [1:0]    st_upd_state;
  logic [CW-1:0] hit_events, hit_cycles, miss_events, miss_cycles;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  longint e_hits = 0, e_miss = 0, e_mcyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  l1_miss_finisher u_dut (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // accepted request; returns stamp of the accepting edge
  task automatic req_go(input logic st, input int a, input int s, input string req, output longint k);
    @(negedge clk);
    cr_valid = 1'b1; cr_store = st; cr_addr = AW'(a); cr_state = 2'(s);
    #1 chk(req, "cr_ready for accepted request", cr_ready, 1);
    k = cyc;
    @(posedge clk);
    @(negedge clk);
    cr_valid = 1'b0;
  endtask

  task automatic probe(input logic st, input int a, input int s, input int exp, input string req);
    @(negedge clk);
    cr_valid = 1'b1; cr_store = st; cr_addr = AW'(a); cr_state = 2'(s);
    #1 chk(req, "cr_ready probe", cr_ready, exp);
    cr_valid = 1'b0;
  endtask

  task automatic rsp_go(input int kind, input int a, input logic inv_same, output longint m);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = 2'(kind); rsp_addr = AW'(a);
    inv_valid = inv_same; inv_addr = AW'(a);
    m = cyc;
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic inv_go(input int a);
    @(negedge clk);
    inv_valid = 1'b1; inv_addr = AW'(a);
    @(posedge clk);
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  // checks a legal miss completion sampled right after the response edge
  task automatic chk_done(input string req, input int a, input int fill, input int ub,
                          input int ubx, input int st, input int nxt, input int dirty,
                          input longint k, input longint m);
    chk(req, "cmpl_valid", cmpl_valid, 1);
    chk(req, "cmpl_miss", cmpl_miss, 1);
    chk(req, "cmpl_store", cmpl_store, st);
    chk(req, "cmpl_addr", cmpl_addr, a);
    chk(req, "fill_valid", fill_valid, fill);
    chk(req, "unblk_valid", unblk_valid, ub);
    if (ub != 0) chk(req, "unblk_excl", unblk_excl, ubx);
    chk(req, "st_upd_state", st_upd_state, nxt);
    chk(req, "st_upd_dirty", st_upd_dirty, dirty);
    chk("R9", "wake_valid", wake_valid, 1);
    chk("R9", "wake_addr", wake_addr, a);
    chk("R10", "proto_err", proto_err, 0);
    e_miss++;
    e_mcyc += m - k + 1;
  endtask

  initial begin
    longint k, m;
    longint ks [4];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "cmpl_valid", cmpl_valid, 0);
    chk("R1", "fill_valid", fill_valid, 0);
    chk("R1", "proto_err", proto_err, 0);
    chk("R1", "miss_events", miss_events, 0);
    chk("R1", "hit_cycles", hit_cycles, 0);
    chk("R1", "cr_ready", cr_ready, 1);
    chk("R9", "rsp_ready", rsp_ready, 1);

    // R2 hits and allocations over both ops and all stable states
    for (int s = 0; s < 2; s++) begin
      for (int st = 0; st < 4; st++) begin
        int a;
        bit hit;
        a = 'h300 + s * 4 + st;
        hit = (s == 1) ? (st >= 2) : (st != 0);
        req_go(s[0], a, st, "R2", k);
        chk("R2", "cmpl_valid", cmpl_valid, hit);
        if (hit) begin
          chk("R2", "cmpl_miss", cmpl_miss, 0);
          chk("R2", "cmpl_store", cmpl_store, s);
          chk("R2", "st_upd_valid", st_upd_valid, s);
          if (s == 1) chk("R2", "store hit state M dirty", {st_upd_state, st_upd_dirty}, 7);
          e_hits++;
        end else begin
          int kind;
          kind = (s == 1 && st == 1) ? 3 : 0;
          rsp_go(kind, a, 1'b0, m);
          if (s == 0) chk_done("R2", a, 1, 0, 0, 0, 1, 0, k, m);
          else if (st == 0) chk_done("R2", a, 1, 1, 1, 1, 3, 1, k, m);
          else chk_done("R2", a, 0, 1, 1, 1, 3, 1, k, m);
        end
      end
    end

    // transient state x response kind sweep (R3 R5 R6 R7 R8 R10)
    for (int ps = 0; ps < 4; ps++) begin
      for (int kd = 0; kd < 4; kd++) begin
        int a;
        bit legal;
        int fill, ub, ubx, stv, nxt, dirty, fixk;
        string rq;
        a = 'h100 + ps * 4 + kd;
        case (ps)
          0: req_go(1'b0, a, 0, "R3", k);
          1: begin req_go(1'b0, a, 0, "R4", k); inv_go(a); end
          2: req_go(1'b1, a, 0, "R7", k);
          default: req_go(1'b1, a, 1, "R8", k);
        endcase
        legal = (ps < 2) ? (kd != 3) : (ps == 2 ? kd == 0 : kd == 3);
        fill = 1; ub = 0; ubx = 0; stv = 0; dirty = 0; nxt = 0; rq = "R3";
        if (ps < 2) begin
          if (kd == 0) begin rq = (ps == 0) ? "R3" : "R4"; nxt = (ps == 0) ? 1 : 0; end
          else if (kd == 1) begin rq = "R5"; ub = 1; nxt = (ps == 0) ? 1 : 0; end
          else begin rq = "R6"; ub = 1; ubx = 1; nxt = 2; end
        end else if (ps == 2) begin
          rq = "R7"; ub = 1; ubx = 1; stv = 1; dirty = 1; nxt = 3;
        end else begin
          rq = "R8"; fill = 0; ub = 1; ubx = 1; stv = 1; dirty = 1; nxt = 3;
        end
        rsp_go(kd, a, 1'b0, m);
        if (legal) begin
          chk_done(rq, a, fill, ub, ubx, stv, nxt, dirty, k, m);
        end else begin
          chk("R10", "proto_err on wrong kind", proto_err, 1);
          chk("R10", "cmpl_valid on wrong kind", cmpl_valid, 0);
          chk("R10", "fill_valid on wrong kind", fill_valid, 0);
          probe(1'b0, a, 1, 0, "R10");
          fixk = (ps == 3) ? 3 : 0;
          rsp_go(fixk, a, 1'b0, m);
          chk_done(rq, a, fill * ((ps == 3) ? 0 : 1), (ps < 2) ? 0 : 1, (ps < 2) ? 0 : 1,
                   stv, (ps < 2) ? ((ps == 0) ? 1 : 0) : 3, dirty, k, m);
          probe(1'b0, a, 1, 1, "R10");
        end
      end
    end

    // R4 invalidate in the same cycle as the data
    req_go(1'b0, 'h400, 0, "R4", k);
    rsp_go(0, 'h400, 1'b1, m);
    chk_done("R4", 'h400, 1, 0, 0, 0, 0, 0, k, m);
    // R4 invalidate on a store miss has no effect
    req_go(1'b1, 'h401, 0, "R4", k);
    inv_go('h401);
    rsp_go(0, 'h401, 1'b0, m);
    chk_done("R4", 'h401, 1, 1, 1, 1, 3, 0 + 1, k, m);

    // R10 response with no entry
    rsp_go(1, 'h777, 1'b0, m);
    chk("R10", "proto_err no entry", proto_err, 1);
    chk("R10", "unblk_valid no entry", unblk_valid, 0);
    chk("R10", "wake_valid no entry", wake_valid, 0);

    // R11 full table, pending address, response priority
    for (int i = 0; i < 4; i++) req_go(1'b0, 'h200 + i, 0, "R11", ks[i]);
    probe(1'b0, 'h204, 0, 0, "R11");
    probe(1'b1, 'h201, 3, 0, "R11");
    req_go(1'b0, 'h205, 1, "R11", k);
    chk("R11", "hit passes full table", cmpl_valid, 1);
    e_hits++;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = 2'd0; rsp_addr = AW'('h201);
    cr_valid = 1'b1; cr_store = 1'b0; cr_addr = AW'('h206); cr_state = 2'd2;
    m = cyc;
    #1 chk("R11", "cr_ready during response", cr_ready, 0);
    @(posedge clk);
    @(negedge clk);
    rsp_valid = 1'b0; cr_valid = 1'b0;
    chk_done("R11", 'h201, 1, 0, 0, 0, 1, 0, ks[1], m);
    for (int i = 0; i < 4; i++) begin
      if (i != 1) begin
        rsp_go(2, 'h200 + i, 1'b0, m);
        chk_done("R6", 'h200 + i, 1, 1, 1, 0, 2, 0, ks[i], m);
      end
    end

    // R12 counters
    @(negedge clk);
    chk("R12", "hit_events", hit_events, e_hits);
    chk("R12", "hit_cycles", hit_cycles, e_hits);
    chk("R12", "miss_events", miss_events, e_miss);
    chk("R12", "miss_cycles", miss_cycles, e_mcyc);

    summary();
    $finish;
  end

endmodule